// File: doc/BRIEF.md
# Two-Level Interrupt Priority Selector

This block chooses the one interrupt a hart should take next. Eight sources compete: the seven standard machine, supervisor and counter-overflow interrupts, and a machine-only domain external interrupt (DXI). DXI is raised when any of 64 domain interrupt lines is asserted and that line's bit is set in a 64-bit domain enable register. Each source is routed to a target mode, machine or supervisor. The block keeps only the sources that are pending, enabled and allowed by the global enable for their target mode at the current privilege. Machine-targeted sources always beat supervisor-targeted ones. Inside one target mode a fixed order decides.

The selection logic is combinational. The chosen cause, the target mode and a valid flag are registered once. The domain enable register is read and written through a small access port. When the register width parameter `XLEN` is 32, one select bit picks the low or the high 32-bit half, and both halves are writable. When `XLEN` is 64, the select bit names a high-half view that does not exist.

Top module: `irq_priority_sel`

## Requirements
- R1: After reset `irq_valid_o` is 0, `irq_cause_o` is 0, `irq_to_m_o` is 0 and every bit of the domain enable register is 0.
- R2: A source is a candidate only if it is pending and enabled. A machine-targeted source additionally needs `priv_i` below machine (3), or `m_ie_i`=1. A supervisor-targeted source additionally needs `priv_i`=0 (user), or `priv_i`=1 (supervisor) with `s_ie_i`=1. It is never a candidate at `priv_i`=3.
- R3: If any machine-targeted candidate exists, the selected interrupt is machine-targeted. A supervisor-targeted source is then not chosen, whatever its rank.
- R4: Within one target mode, priority from highest to lowest is MEI, MSI, MTI, DXI, SEI, SSI, STI, LCOFI.
- R5: The pending, enable and delegation vectors are indexed by cause code: SSI=1, MSI=3, STI=5, MTI=7, SEI=9, MEI=11, LCOFI=13. `irq_cause_o` carries that code. DXI reports `SDEI_CAUSE`, which defaults to 32.
- R6: SSI, STI, SEI and LCOFI target supervisor mode when their delegation bit is 1 and machine mode otherwise. MSI, MTI, MEI and DXI always target machine mode, regardless of any delegation bit.
- R7: DXI is pending exactly when some bit k of `sd_pend_i` is 1 and bit k of the domain enable register is 1.
- R8: With no candidate, `irq_valid_o`=0, `irq_cause_o`=0 and `irq_to_m_o`=0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. Input changes between edges do not affect them.
- R10: With `XLEN`=64, a write with `sden_hi_i`=0 loads all 64 bits, and a read with `sden_hi_i`=0 returns them. A write with `sden_hi_i`=1 has no effect, and a read with `sden_hi_i`=1 returns 0.
- R11: With `XLEN`=32, `sden_hi_i`=0 reads and writes bits 31:0, and `sden_hi_i`=1 reads and writes bits 63:32. A write to one half leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| irq_pend_i | input | 16 | Pending bits, indexed by cause code |
| irq_en_i | input | 16 | Enable bits, indexed by cause code |
| irq_deleg_i | input | 16 | Delegation bits, indexed by cause code |
| sd_pend_i | input | 64 | Domain interrupt lines |
| sden_we_i | input | 1 | Domain enable register write strobe |
| sden_hi_i | input | 1 | Selects the high half view |
| sden_wdata_i | input | XLEN | Write data |
| sden_rdata_o | output | XLEN | Read data for the selected view |
| irq_valid_o | output | 1 | An interrupt is selected |
| irq_cause_o | output | CAUSE_W | Cause code of the selected interrupt |
| irq_to_m_o | output | 1 | Selected interrupt targets machine mode |

## Verification
The assertions assume that `priv_i` never takes the reserved value 2. They also assume that the register width parameter is 32 or 64, which the bench guarantees by drawing privilege only from {0, 1, 3} and instantiating only those two widths. The ordering assertions also assume that the candidate vectors carry no unknowns while out of reset. The bench therefore drives every input from reset onward and never leaves one floating. Random vectors draw domain lines and enable bits sparsely, so DXI appears both alone and in contention with the standard sources.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int NUM_SRC = 8;
  localparam int STD_W   = 16;
  localparam int SD_W    = 64;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int DXI_IDX = 3;
  localparam int MACH_LAST = 3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // source index is its rank: 0 is highest
  function automatic int src_cause(int idx, int dxi_cause);
    case (idx)
      0:       return 11;
      1:       return 3;
      2:       return 7;
      3:       return dxi_cause;
      4:       return 9;
      5:       return 1;
      6:       return 5;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/irqsel_sden.sv
module irqsel_sden #(
  parameter int XLEN = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         hi_i,
  input  logic [XLEN-1:0]              wdata_i,
  output logic [XLEN-1:0]              rdata_o,
  output logic [irqsel_pkg::SD_W-1:0]  en_o
);
  import irqsel_pkg::*;

  logic [SD_W-1:0] en_q;

  if (XLEN == 32) begin : g_split
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= '0;
      else if (we_i) begin
        if (hi_i) en_q[63:32] <= wdata_i;
        else      en_q[31:0]  <= wdata_i;
      end
    end
    assign rdata_o = hi_i ? en_q[63:32] : en_q[31:0];

    a_r11_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && hi_i |=> en_o[31:0] == $past(en_o[31:0]));
    a_r11_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && !hi_i |=> en_o[63:32] == $past(en_o[63:32]));
  end else begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             en_q <= '0;
      else if (we_i && !hi_i)  en_q <= wdata_i;
    end
    assign rdata_o = hi_i ? '0 : en_q;

    a_r10_hi_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && hi_i |=> $stable(en_o));
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqsel_route.sv
module irqsel_route #(
  parameter int SDEI_CAUSE = 32
) (
  input  logic [1:0]                       priv_i,
  input  logic                             m_ie_i,
  input  logic                             s_ie_i,
  input  logic [irqsel_pkg::STD_W-1:0]     pend_i,
  input  logic [irqsel_pkg::STD_W-1:0]     en_i,
  input  logic [irqsel_pkg::STD_W-1:0]     deleg_i,
  input  logic                             dxi_pend_i,
  output logic [irqsel_pkg::NUM_SRC-1:0]   m_cand_o,
  output logic [irqsel_pkg::NUM_SRC-1:0]   s_cand_o
);
  import irqsel_pkg::*;

  logic m_glob, s_glob;
  assign m_glob = (priv_i != PRIV_M) || m_ie_i;
  assign s_glob = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_ie_i);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == DXI_IDX) begin : g_dxi
      assign m_cand_o[i] = dxi_pend_i && m_glob;
      assign s_cand_o[i] = 1'b0;
    end else begin : g_std
      localparam int C = src_cause(i, SDEI_CAUSE);
      logic live, to_s;
      assign live = pend_i[C] && en_i[C];
      assign to_s = (i > MACH_LAST) && deleg_i[C];
      assign m_cand_o[i] = live && !to_s && m_glob;
      assign s_cand_o[i] = live && to_s && s_glob;
    end
  end

  // unmapped positions are accepted but have no effect
  logic spare;
  assign spare = ^{pend_i, en_i, deleg_i};
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [irqsel_pkg::NUM_SRC-1:0]   m_cand_i,
  input  logic [irqsel_pkg::NUM_SRC-1:0]   s_cand_i,
  output logic                             valid_o,
  output logic                             to_m_o,
  output logic [irqsel_pkg::IDX_W-1:0]     idx_o
);
  import irqsel_pkg::*;

  logic [NUM_SRC-1:0] vec;

  always_comb begin
    to_m_o = |m_cand_i;
    vec    = to_m_o ? m_cand_i : s_cand_i;
    idx_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (vec[i]) idx_o = IDX_W'(i);
    valid_o = |vec;
  end

  logic [NUM_SRC-1:0] sel_cand, above_mask;
  assign sel_cand   = to_m_o ? m_cand_i : s_cand_i;
  assign above_mask = (NUM_SRC'(1) << idx_o) - NUM_SRC'(1);

  a_r4_pick_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sel_cand[idx_o]);
  a_r4_none_ranked_higher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sel_cand & above_mask) == '0);
  a_r3_machine_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !to_m_o |-> m_cand_i == '0);
endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel #(
  parameter int XLEN       = 32,
  parameter int SDEI_CAUSE = 32,
  parameter int CAUSE_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           priv_i,
  input  logic                 m_ie_i,
  input  logic                 s_ie_i,
  input  logic [15:0]          irq_pend_i,
  input  logic [15:0]          irq_en_i,
  input  logic [15:0]          irq_deleg_i,
  input  logic [63:0]          sd_pend_i,
  input  logic                 sden_we_i,
  input  logic                 sden_hi_i,
  input  logic [XLEN-1:0]      sden_wdata_i,
  output logic [XLEN-1:0]      sden_rdata_o,
  output logic                 irq_valid_o,
  output logic [CAUSE_W-1:0]   irq_cause_o,
  output logic                 irq_to_m_o
);
  import irqsel_pkg::*;

  logic [SD_W-1:0]    sd_en;
  logic               dxi_pend;
  logic [NUM_SRC-1:0] m_cand, s_cand;
  logic               sel_valid, sel_to_m;
  logic [IDX_W-1:0]   sel_idx;
  logic [CAUSE_W-1:0] cause_d;

  irqsel_sden #(.XLEN(XLEN)) i_sden (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sden_we_i),
    .hi_i    (sden_hi_i),
    .wdata_i (sden_wdata_i),
    .rdata_o (sden_rdata_o),
    .en_o    (sd_en)
  );

  assign dxi_pend = |(sd_pend_i & sd_en);

  irqsel_route #(.SDEI_CAUSE(SDEI_CAUSE)) i_route (
    .priv_i     (priv_i),
    .m_ie_i     (m_ie_i),
    .s_ie_i     (s_ie_i),
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .deleg_i    (irq_deleg_i),
    .dxi_pend_i (dxi_pend),
    .m_cand_o   (m_cand),
    .s_cand_o   (s_cand)
  );

  irqsel_pick i_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .m_cand_i (m_cand),
    .s_cand_i (s_cand),
    .valid_o  (sel_valid),
    .to_m_o   (sel_to_m),
    .idx_o    (sel_idx)
  );

  always_comb begin
    cause_d = '0;
    if (sel_valid) cause_d = CAUSE_W'(src_cause(int'(sel_idx), SDEI_CAUSE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_cause_o <= '0;
      irq_to_m_o  <= 1'b0;
    end else begin
      irq_valid_o <= sel_valid;
      irq_cause_o <= cause_d;
      irq_to_m_o  <= sel_valid && sel_to_m;
    end
  end

  a_r8_idle_outputs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_cause_o == '0 && !irq_to_m_o);
  a_r6_dxi_machine_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_cause_o == CAUSE_W'(SDEI_CAUSE) |-> irq_to_m_o);
  a_r9_valid_tracks_candidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_valid_o == $past(|{m_cand, s_cand}));
  a_r7_dxi_needs_enabled_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_cand[DXI_IDX] |-> (sd_pend_i & sd_en) != '0);
endmodule

// File: tb/test_irq_priority_sel.sv
`timescale 1ns/1ps
module test_irq_priority_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic        m_ie = 1'b0, s_ie = 1'b0;
  logic [15:0] pend = '0, en = '0, deleg = '0;
  logic [63:0] sd_pend = '0;
  logic        we = 1'b0, hi = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        we64 = 1'b0, hi64 = 1'b0;
  logic [63:0] wdata64 = '0;
  logic [63:0] rdata64;
  logic        valid, to_m, valid64, to_m64;
  logic [5:0]  cause, cause64;

  logic [63:0] sd_en_m = '0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_priority_sel #(.XLEN(32)) i_irq_priority_sel (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .m_ie_i(m_ie), .s_ie_i(s_ie),
    .irq_pend_i(pend), .irq_en_i(en), .irq_deleg_i(deleg), .sd_pend_i(sd_pend),
    .sden_we_i(we), .sden_hi_i(hi), .sden_wdata_i(wdata), .sden_rdata_o(rdata),
    .irq_valid_o(valid), .irq_cause_o(cause), .irq_to_m_o(to_m));

  irq_priority_sel #(.XLEN(64)) i_irq_priority_sel_x64 (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .m_ie_i(m_ie), .s_ie_i(s_ie),
    .irq_pend_i(pend), .irq_en_i(en), .irq_deleg_i(deleg), .sd_pend_i(sd_pend),
    .sden_we_i(we64), .sden_hi_i(hi64), .sden_wdata_i(wdata64), .sden_rdata_o(rdata64),
    .irq_valid_o(valid64), .irq_cause_o(cause64), .irq_to_m_o(to_m64));

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // {valid, to_m, cause[5:0]}
  function automatic logic [7:0] model();
    int ord[8] = '{11, 3, 7, 32, 9, 1, 5, 13};
    bit m_ok, s_ok, dxi;
    m_ok = (priv != 2'd3) || m_ie;
    s_ok = (priv == 2'd0) || (priv == 2'd1 && s_ie);
    dxi  = |(sd_pend & sd_en_m);
    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < 8; k++) begin
        int c = ord[k];
        bit live = (c == 32) ? dxi : (pend[c] && en[c]);
        bit to_s = (k > 3) && deleg[c];
        if (live && pass == 0 && !to_s && m_ok) return {1'b1, 1'b1, 6'(c)};
        if (live && pass == 1 && to_s && s_ok)  return {1'b1, 1'b0, 6'(c)};
      end
    return 8'h00;
  endfunction

  task automatic step(string req);
    logic [7:0] e = model();
    @(posedge clk); @(negedge clk);
    chk({req, " valid"}, valid, e[7]);
    chk({req, " to_m"},  to_m,  e[6]);
    chk({req, " cause"}, cause, e[5:0]);
  endtask

  task automatic wr32(logic h, logic [31:0] d);
    we = 1'b1; hi = h; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    if (h) sd_en_m[63:32] = d; else sd_en_m[31:0] = d;
  endtask

  task automatic wr64(logic h, logic [63:0] d);
    we64 = 1'b1; hi64 = h; wdata64 = d;
    @(posedge clk); @(negedge clk);
    we64 = 1'b0;
  endtask

  task automatic set_only(int c);
    pend = '0; sd_pend = '0;
    if (c == 32) sd_pend = 64'h1 << 5;
    else pend[c] = 1'b1;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int ord[8] = '{11, 3, 7, 32, 9, 1, 5, 13};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1 valid", valid, 0); chk("R1 cause", cause, 0); chk("R1 to_m", to_m, 0);
    rst_n = 1'b1;
    @(negedge clk);
    hi = 1'b0; #0.1 chk("R1 reg lo", rdata, 0);
    hi = 1'b1; #0.1 chk("R1 reg hi", rdata, 0);
    hi = 1'b0;

    // R8 nothing pending
    en = 16'hFFFF; step("R8");

    // R5 each source alone, user mode, nothing delegated; low half enables line 5
    wr32(1'b0, 32'h0000_0020);
    for (int k = 0; k < 8; k++) begin set_only(ord[k]); step("R5"); end

    // R4 drop the top source one by one
    pend = 16'hFFFF; sd_pend = 64'h20;
    for (int k = 0; k < 8; k++) begin
      step("R4");
      if (ord[k] == 32) sd_pend = '0; else pend[ord[k]] = 1'b0;
    end

    // R3 machine LCOFI beats delegated SEI; R6 delegation bits on machine sources ignored
    priv = 2'd0; deleg = 16'h0200; pend = 16'h2200; step("R3");
    deleg = 16'hFFFF; pend = 16'h0080; step("R6 MTI");
    set_only(32); step("R6 DXI");
    pend = 16'h0002; sd_pend = '0; step("R6 SSI deleg");

    // R2 global enables
    deleg = 16'h0000; pend = 16'h0800; priv = 2'd3; m_ie = 1'b0; step("R2 M masked");
    m_ie = 1'b1; step("R2 M enabled");
    deleg = 16'h0200; pend = 16'h0200; s_ie = 1'b1; step("R2 S at M");
    priv = 2'd1; s_ie = 1'b0; step("R2 S masked");
    s_ie = 1'b1; step("R2 S enabled");
    en = 16'hFDFF; step("R2 disabled");
    en = 16'hFFFF;

    // R7 and R11: line 40 needs high-half bit 8
    priv = 2'd0; pend = '0; sd_pend = 64'h1 << 40; step("R7 off");
    wr32(1'b1, 32'h0000_0100); step("R7 on");
    hi = 1'b1; #0.1 chk("R11 hi read", rdata, 32'h100);
    hi = 1'b0; #0.1 chk("R11 lo kept", rdata, 32'h20);
    wr32(1'b0, 32'hA5A5_0000);
    hi = 1'b1; #0.1 chk("R11 hi kept", rdata, 32'h100);
    hi = 1'b0; #0.1 chk("R11 lo read", rdata, 32'hA5A5_0000);

    // R10 full-width register
    wr64(1'b0, 64'h1234_5678_9ABC_DEF0);
    hi64 = 1'b0; #0.1 chk("R10 full read", rdata64, 64'h1234_5678_9ABC_DEF0);
    wr64(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    hi64 = 1'b0; #0.1 chk("R10 hi write ignored", rdata64, 64'h1234_5678_9ABC_DEF0);
    hi64 = 1'b1; #0.1 chk("R10 hi read zero", rdata64, 64'h0);
    hi64 = 1'b0;

    // R9 outputs hold between edges
    pend = 16'h0800; sd_pend = '0; step("R9 setup");
    pend = 16'h0000; #1;
    chk("R9 hold valid", valid, 1); chk("R9 hold cause", cause, 11);
    step("R9 after edge");

    // random mix: R2 R3 R4 R6 R7
    for (int n = 0; n < 600; n++) begin
      int pr = $urandom % 3;
      if (n % 16 == 0) wr32(1'($urandom), $urandom & $urandom & $urandom);
      priv  = (pr == 2) ? 2'd3 : 2'(pr);
      m_ie  = 1'($urandom); s_ie = 1'($urandom);
      pend  = 16'($urandom & $urandom);
      en    = 16'($urandom | $urandom);
      deleg = 16'($urandom);
      sd_pend = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      step("R4 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule